// File: doc/BRIEF.md
# Interrupt-Aware Control and Status Register Block

This block is the software-facing register set of a peripheral. It sits on a simple 32-bit memory-mapped slave port with cycle, strobe and write-enable signals. Through that port software reaches five things: a control word whose implemented bits drive the peripheral, a status word that shows the filtered level of each event line, a sticky interrupt cause word, an interrupt mask, and one event counter for each source.

Each event line is asynchronous to the bus clock. A line first passes through a two-flop synchroniser. A filter then accepts a new level only after three equal samples in a row. A rising edge of the filtered level is one event. That event sets the source's sticky cause bit and advances its saturating counter. Because the counter advances whether or not the cause was cleared, the peripheral keeps running when interrupts go unserviced.

The top bit of the cause word is a live OR of every enabled cause. A signed read of that word is therefore negative exactly when some enabled cause is pending. The interrupt output follows that same bit.

Top module: `irq_csr_top`

## Requirements
- R1: After reset, reads of control (0x0), status (0x4), cause (0x8), mask (0xC) and every counter return 0, and irq_o and ctrl_o are 0.
- R2: The control word at 0x0 is read-write. A read returns the value last written to bits [CTRL_W-1:0], and ctrl_o carries those bits. Reserved bits read as 0 and do not appear on ctrl_o.
- R3: Status bit i at 0x4 reads the filtered level of event line i, for i below NUM_SRC. All other status bits read as 0.
- R4: A line must hold its new level for 3 consecutive synchronised samples before it is accepted. A high pulse of 2 clocks produces no status change, no cause bit and no count.
- R5: A rising edge of filtered line i sets cause bit i at 0x8. The bit stays set after the line falls.
- R6: Writing 1 to cause bit i clears it, and writing 0 leaves it unchanged. An event that arrives in the same cycle as a clear leaves the bit set.
- R7: Cause bit 31 reads as the OR over i of (cause bit i AND mask bit i), where the mask sits at 0xC in bits [NUM_SRC-1:0]. irq_o equals bit 31, and writes to bit 31 are ignored.
- R8: The counter for source i sits at 0x10+4*i in bits [CNT_W-1:0]. It advances by one on every event, even while the cause bit is still set. It saturates at 2^CNT_W-1, and any write to its address clears it to 0.
- R9: Each access with cyc_i and stb_i high is acknowledged with ack_o high for exactly one cycle, on the clock after the strobe is taken. A read of an unmapped or unaligned address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cyc_i | input | 1 | Bus cycle valid |
| stb_i | input | 1 | Access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| adr_i | input | ADR_W | Byte address |
| dat_i | input | 32 | Write data |
| dat_o | output | 32 | Read data, valid with ack_o |
| ack_o | output | 1 | Access acknowledge |
| evt_ai | input | NUM_SRC | Asynchronous event lines |
| ctrl_o | output | CTRL_W | Implemented control bits |
| irq_o | output | 1 | Interrupt request, equal to cause bit 31 |

## Verification
A stuck or lost cause bit shows up on the first read of 0x8, and through bit 31 and irq_o as soon as its mask bit is set. A filter that lets a short pulse through shows up as a nonzero cause or counter within about eight clocks of the pulse. A counter that wraps instead of saturating reads as a small number after the sixteenth event of a 4-bit bench build. A wrong ack or decode shows up on the very next access, as an ack in the wrong cycle or nonzero data from an unmapped address.

// File: rtl/irq_csr_pkg.sv
package irq_csr_pkg;
  localparam int unsigned BUS_W     = 32;
  localparam int unsigned WORD_CTRL = 0;
  localparam int unsigned WORD_STAT = 1;
  localparam int unsigned WORD_ISR  = 2;
  localparam int unsigned WORD_MASK = 3;
  localparam int unsigned WORD_CNT0 = 4;
  localparam int unsigned SUM_BIT   = 31;
endpackage

// File: rtl/irq_evt_input.sv
module irq_evt_input #(
  parameter int unsigned FILT_LEN = 3
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic evt_ai,
  output logic level_o,
  output logic rise_p1_o
);
  logic                meta_q, sync_q;
  logic [FILT_LEN-1:0] hist_q, hist_d;
  logic                level_q, level_d;
  logic                rise_q, rise_d;

  always_comb begin
    hist_d  = {hist_q[FILT_LEN-2:0], sync_q};
    level_d = level_q;
    if (&hist_q)      level_d = 1'b1;
    else if (~|hist_q) level_d = 1'b0;
    rise_d  = level_d & ~level_q;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      meta_q  <= 1'b0;
      sync_q  <= 1'b0;
      hist_q  <= '0;
      level_q <= 1'b0;
      rise_q  <= 1'b0;
    end else begin
      meta_q  <= evt_ai;
      sync_q  <= meta_q;
      hist_q  <= hist_d;
      level_q <= level_d;
      rise_q  <= rise_d;
    end
  end

  assign level_o   = level_q;
  assign rise_p1_o = rise_q;
endmodule

// File: rtl/irq_evt_counter.sv
module irq_evt_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d, base;

  always_comb begin
    base  = clr_i ? '0 : cnt_q;
    cnt_d = base;
    if (inc_i && (base != CNT_MAX)) cnt_d = base + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) cnt_q <= '0;
    else if (clr_i || inc_i) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/irq_csr_top.sv
module irq_csr_top
  import irq_csr_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 4,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned CTRL_W   = 8,
  parameter int unsigned ADR_W    = 8,
  parameter int unsigned FILT_LEN = 3
) (
  input  logic               clk_i,
  input  logic               rst_n_i,
  input  logic               cyc_i,
  input  logic               stb_i,
  input  logic               we_i,
  input  logic [ADR_W-1:0]   adr_i,
  input  logic [BUS_W-1:0]   dat_i,
  output logic [BUS_W-1:0]   dat_o,
  output logic               ack_o,
  input  logic [NUM_SRC-1:0] evt_ai,
  output logic [CTRL_W-1:0]  ctrl_o,
  output logic               irq_o
);
  localparam int unsigned WORD_W = ADR_W - 2;

  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [NUM_SRC-1:0]       lvl, evt_p1, cnt_clr;
  logic [CNT_W-1:0]         cnt [NUM_SRC];
  logic [NUM_SRC*CNT_W-1:0] cnt_flat;

  logic              req, wr, rd, aligned;
  logic [WORD_W-1:0] word;

  assign req     = cyc_i & stb_i & ~ack_o;
  assign wr      = req & we_i;
  assign rd      = req & ~we_i;
  assign aligned = (adr_i[1:0] == 2'b00);
  assign word    = adr_i[ADR_W-1:2];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    irq_evt_input #(.FILT_LEN(FILT_LEN)) u_in (
      .clk_i    (clk_i),
      .rst_n_i  (rst_sync_n),
      .evt_ai   (evt_ai[g]),
      .level_o  (lvl[g]),
      .rise_p1_o(evt_p1[g])
    );
    assign cnt_clr[g] = wr & aligned & (word == WORD_W'(WORD_CNT0 + g));
    irq_evt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_n_i(rst_sync_n),
      .clr_i  (cnt_clr[g]),
      .inc_i  (evt_p1[g]),
      .count_o(cnt[g])
    );
    assign cnt_flat[g*CNT_W +: CNT_W] = cnt[g];
  end

  logic [CTRL_W-1:0]  ctrl_q, ctrl_d;
  logic [NUM_SRC-1:0] mask_q, mask_d;
  logic [NUM_SRC-1:0] cause_q, cause_d, clr_bits;
  logic [BUS_W-1:0]   dat_q, rdata;
  logic               ack_q, ack_d;
  logic               ctrl_en, mask_en, summary;

  assign summary  = |(cause_q & mask_q);
  assign ctrl_en  = wr & aligned & (word == WORD_W'(WORD_CTRL));
  assign mask_en  = wr & aligned & (word == WORD_W'(WORD_MASK));
  assign clr_bits = (wr && aligned && (word == WORD_W'(WORD_ISR)))
                    ? dat_i[NUM_SRC-1:0] : '0;

  always_comb begin
    ctrl_d  = dat_i[CTRL_W-1:0];
    mask_d  = dat_i[NUM_SRC-1:0];
    cause_d = (cause_q & ~clr_bits) | evt_p1;
    ack_d   = req;
  end

  always_comb begin
    rdata = '0;
    if (aligned) begin
      if (word == WORD_W'(WORD_CTRL)) rdata[CTRL_W-1:0]  = ctrl_q;
      if (word == WORD_W'(WORD_STAT)) rdata[NUM_SRC-1:0] = lvl;
      if (word == WORD_W'(WORD_ISR)) begin
        rdata[NUM_SRC-1:0] = cause_q;
        rdata[SUM_BIT]     = summary;
      end
      if (word == WORD_W'(WORD_MASK)) rdata[NUM_SRC-1:0] = mask_q;
      for (int i = 0; i < NUM_SRC; i++) begin
        if (word == WORD_W'(WORD_CNT0 + i)) rdata[CNT_W-1:0] = cnt[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      ctrl_q  <= '0;
      mask_q  <= '0;
      cause_q <= '0;
      dat_q   <= '0;
      ack_q   <= 1'b0;
    end else if (!rst_sync_n) begin
      ctrl_q  <= '0;
      mask_q  <= '0;
      cause_q <= '0;
      dat_q   <= '0;
      ack_q   <= 1'b0;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      if (mask_en) mask_q <= mask_d;
      cause_q <= cause_d;
      if (rd) dat_q <= rdata;
      ack_q <= ack_d;
    end
  end

  assign ack_o  = ack_q;
  assign dat_o  = dat_q;
  assign ctrl_o = ctrl_q;
  assign irq_o  = summary;
endmodule

// File: rtl/irq_csr_sva.sv
module irq_csr_sva #(
  parameter int unsigned NUM_SRC = 4,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned CTRL_W  = 8,
  parameter int unsigned ADR_W   = 8
) (
  input logic                     clk_i,
  input logic                     rst_n,
  input logic                     cyc_i,
  input logic                     stb_i,
  input logic                     we_i,
  input logic [ADR_W-1:0]         adr_i,
  input logic [31:0]              dat_i,
  input logic [31:0]              dat_o,
  input logic                     ack_o,
  input logic                     irq_o,
  input logic [CTRL_W-1:0]        ctrl_o,
  input logic [NUM_SRC-1:0]       cause,
  input logic [NUM_SRC-1:0]       mask,
  input logic [NUM_SRC-1:0]       evt,
  input logic [NUM_SRC*CNT_W-1:0] cnt_flat
);
  logic take, rd_isr, wr_isr, wr_ctrl;
  assign take    = cyc_i & stb_i & ~ack_o;
  assign rd_isr  = take & ~we_i & (adr_i == ADR_W'(8));
  assign wr_isr  = take &  we_i & (adr_i == ADR_W'(8));
  assign wr_ctrl = take &  we_i & (adr_i == ADR_W'(0));

  assert_ack_next_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    take |=> ack_o);
  assert_ack_single_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    ack_o |=> !ack_o);
  assert_sign_bit_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    rd_isr |=> (dat_o[31] == $past(irq_o)));
  assert_mask_gates_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (mask == '0) |-> !irq_o);
  assert_ctrl_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    !wr_ctrl |=> $stable(ctrl_o));

  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
    assert_cause_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
      (cause[i] && !(wr_isr && dat_i[i])) |=> cause[i]);
    assert_evt_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
      evt[i] |=> cause[i]);
    assert_cnt_saturate_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
      ((cnt_flat[i*CNT_W +: CNT_W] == CMAX) &&
       !(take && we_i && (adr_i == ADR_W'(16 + 4*i))))
      |=> (cnt_flat[i*CNT_W +: CNT_W] == CMAX));
  end
endmodule

bind irq_csr_top irq_csr_sva #(
  .NUM_SRC(NUM_SRC), .CNT_W(CNT_W), .CTRL_W(CTRL_W), .ADR_W(ADR_W)
) u_sva (
  .clk_i   (clk_i),
  .rst_n   (rst_sync_n),
  .cyc_i   (cyc_i),
  .stb_i   (stb_i),
  .we_i    (we_i),
  .adr_i   (adr_i),
  .dat_i   (dat_i),
  .dat_o   (dat_o),
  .ack_o   (ack_o),
  .irq_o   (irq_o),
  .ctrl_o  (ctrl_o),
  .cause   (cause_q),
  .mask    (mask_q),
  .evt     (evt_p1),
  .cnt_flat(cnt_flat)
);

// File: tb/irq_csr_top_tb.sv
module irq_csr_top_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NSRC = 4;
  localparam int  CW   = 4;
  localparam int  CTW  = 8;
  localparam int  AW   = 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            cyc, stb, we;
  logic [AW-1:0]   adr;
  logic [31:0]     wdat, rdat;
  logic            ack;
  logic [NSRC-1:0] evt;
  logic [CTW-1:0]  ctrl;
  logic            irq;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_csr_top #(.NUM_SRC(NSRC), .CNT_W(CW), .CTRL_W(CTW), .ADR_W(AW)) u_dut (
    .clk_i(clk), .rst_n_i(rst_n), .cyc_i(cyc), .stb_i(stb), .we_i(we),
    .adr_i(adr), .dat_i(wdat), .dat_o(rdat), .ack_o(ack),
    .evt_ai(evt), .ctrl_o(ctrl), .irq_o(irq)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [AW-1:0] a,
                     input logic [31:0] d, output logic [31:0] q);
    @(negedge clk);
    cyc = 1'b1; stb = 1'b1; we = w; adr = a; wdat = d;
    @(negedge clk);
    check("R9 ack", {31'd0, ack}, 32'd1);
    q = rdat;
    cyc = 1'b0; stb = 1'b0; we = 1'b0;
    @(negedge clk);
    check("R9 ack drop", {31'd0, ack}, 32'd0);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    logic [31:0] q;
    bus(1'b1, a, d, q);
  endtask

  task automatic rd_chk(string req, input logic [AW-1:0] a, input logic [31:0] exp);
    logic [31:0] q;
    bus(1'b0, a, 32'd0, q);
    check(req, q, exp);
  endtask

  task automatic pulse(int src, int hi_cycles);
    @(negedge clk); evt[src] = 1'b1;
    repeat (hi_cycles) @(negedge clk);
    evt[src] = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic t_reset;
    rd_chk("R1 ctrl", 8'h00, 0);
    rd_chk("R1 status", 8'h04, 0);
    rd_chk("R1 cause", 8'h08, 0);
    rd_chk("R1 mask", 8'h0C, 0);
    for (int i = 0; i < NSRC; i++) rd_chk("R1 counter", AW'(16 + 4*i), 0);
    check("R1 irq", {31'd0, irq}, 0);
    check("R1 ctrl_o", {24'd0, ctrl}, 0);
  endtask

  task automatic t_ctrl;
    wr(8'h00, 32'hA5A5_5A3C);
    rd_chk("R2 readback", 8'h00, 32'h0000_003C);
    check("R2 ctrl_o", {24'd0, ctrl}, 32'h3C);
    wr(8'h00, 32'h0000_00C1);
    rd_chk("R2 readback2", 8'h00, 32'h0000_00C1);
    wr(8'h00, 32'h0);
    check("R2 ctrl_o clear", {24'd0, ctrl}, 0);
  endtask

  task automatic t_decode;
    rd_chk("R9 unmapped", 8'h40, 0);
    rd_chk("R9 past counters", 8'h20, 0);
    rd_chk("R9 unaligned", 8'h09, 0);
  endtask

  task automatic t_status;
    @(negedge clk); evt[0] = 1'b1;
    repeat (10) @(negedge clk);
    rd_chk("R3 status high", 8'h04, 32'h1);
    evt[0] = 1'b0;
    repeat (10) @(negedge clk);
    rd_chk("R3 status low", 8'h04, 32'h0);
    rd_chk("R5 sticky after fall", 8'h08, 32'h1);
  endtask

  task automatic t_glitch;
    wr(8'h08, 32'h7FFF_FFFF);
    rd_chk("R6 clear all", 8'h08, 0);
    pulse(1, 2);
    rd_chk("R4 glitch no cause", 8'h08, 0);
    rd_chk("R4 glitch no count", 8'h14, 0);
    pulse(1, 3);
    rd_chk("R4 three samples accepted", 8'h14, 32'h1);
  endtask

  task automatic t_cause;
    wr(8'h08, 32'h7FFF_FFFF);
    pulse(2, 6);
    rd_chk("R5 cause set", 8'h08, 32'h4);
    check("R7 masked irq", {31'd0, irq}, 0);
    wr(8'h0C, 32'h4);
    rd_chk("R7 mask readback", 8'h0C, 32'h4);
    check("R7 irq on", {31'd0, irq}, 1);
    rd_chk("R7 sign bit", 8'h08, 32'h8000_0004);
    wr(8'h08, 32'h8000_0000);
    rd_chk("R7 bit31 write ignored", 8'h08, 32'h8000_0004);
    wr(8'h08, 32'h0);
    rd_chk("R6 write zero keeps", 8'h08, 32'h8000_0004);
    wr(8'h08, 32'h4);
    rd_chk("R6 write one clears", 8'h08, 0);
    check("R7 irq off", {31'd0, irq}, 0);
    wr(8'h0C, 32'h0);
  endtask

  task automatic t_counter;
    wr(8'h1C, 32'hFFFF_FFFF);
    for (int k = 0; k < 3; k++) pulse(3, 5);
    rd_chk("R8 counts unserviced", 8'h1C, 32'd3);
    rd_chk("R5 cause while counting", 8'h08, 32'h8);
    wr(8'h1C, 32'h0);
    rd_chk("R8 write clears", 8'h1C, 0);
    for (int k = 0; k < 20; k++) pulse(3, 5);
    rd_chk("R8 saturates", 8'h1C, 32'd15);
    rd_chk("R8 other counter untouched", 8'h18, 32'd1);
  endtask

  initial begin
    rst_n = 1'b0; cyc = 1'b0; stb = 1'b0; we = 1'b0;
    adr = '0; wdat = '0; evt = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_ctrl();
    t_decode();
    t_status();
    t_glitch();
    t_cause();
    t_counter();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule